// File: doc/BRIEF.md
# Synchronous Burst Static RAM (flow-through)

This block is a cycle-level model of a synchronous burst static RAM whose words are split into byte lanes of nine bits each: eight data bits plus one parity bit. Every rising clock edge it decodes three chip enables, two address strobes, a burst-advance input, a set of write controls and a snooze input. From these it either opens a new burst at the external address, steps or holds the current burst, writes the selected lanes, or deselects. The word array has 2^ADDR_W entries, so a small depth keeps simulation fast.

Reads are flow-through. The read port of the array is driven straight from the registered burst address, so read data for a beat appears in the cycle after the edge that selected that beat, with no output register in the path. Output enable and snooze act on the output combinationally. A valid flag takes the place of a tristate bus: when it is low the data output is held at zero.

The address strobe meant for a processor always opens a read. A write can follow it on the next edge. The address strobe meant for a controller can open a read or a write on its own edge. A two-bit beat counter on the two low address bits gives four-beat bursts in linear or interleaved order.

Top module: `sbsram_core`

## Requirements
- R1: Bit layout: lane 0 is `din[8:0]` with parity in bit 8, and lane 1 is `din[17:9]` with parity in bit 17. Lane i is written when `wr_all_n` is low, or when `wr_mask_en_n` and `wr_lane_n[i]` are both low. Lanes that are not enabled keep their stored value.
- R2: When `wr_all_n` is high and either `wr_mask_en_n` is high or every `wr_lane_n` bit is high, the cycle is a read and no lane is written.
- R3: `cpu_ads_n` low together with `en_n` low, while the block is fully selected (`en_hi` high, `en_lo_n` low), latches `addr` as the burst start and makes the cycle a read, whatever the write controls say on that edge.
- R4: After a `cpu_ads_n` start, an edge with both strobes high, `burst_adv_n` high and the write controls asserted writes `din` to the same address.
- R5: `ctl_ads_n` low while fully selected (and no R3 start on that edge) latches `addr`. If the write controls are asserted, it also writes `din` there on that edge; otherwise the cycle is a read.
- R6: A strobe start while not fully selected is a deselect: no address is latched, nothing is written, and `dout_vld` stays low until the next start. This covers `ctl_ads_n` low, or `cpu_ads_n` low with `en_n` low.
- R7: With both strobes inactive during a burst, `burst_adv_n` low steps the beat count. The low two address bits become start+count modulo 4 when `ilv_mode`=0, or start XOR count when `ilv_mode`=1. The upper bits stay fixed and the burst wraps after four beats. The step applies to reads and writes alike.
- R8: With both strobes inactive, `burst_adv_n` high keeps the current address (a wait state). Reads repeat the same word and writes go to the same word.
- R9: While `snooze` is high, `dout_vld` is low, no write occurs and the burst state is frozen. Once `snooze` falls, the burst resumes from the beat it was on.
- R10: `dout_vld` is high only in a read cycle of an active burst with `out_en_n` low and `snooze` low. It follows `out_en_n` within the same cycle. When `dout_vld` is low, `dout` is zero.
- R11: The cycle after a write edge has `dout_vld` low, whatever `out_en_n` is.
- R12: In a read cycle, `dout` equals the stored word at the current burst address. This includes data written on earlier edges.
- R13: After reset, no burst is active and `dout_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_n | input | 1 | Primary chip enable, active low |
| en_hi | input | 1 | Secondary chip enable, active high |
| en_lo_n | input | 1 | Secondary chip enable, active low |
| cpu_ads_n | input | 1 | Processor address strobe, active low, always starts a read |
| ctl_ads_n | input | 1 | Controller address strobe, active low, starts a read or a write |
| burst_adv_n | input | 1 | Burst advance, low steps the beat, high holds it |
| wr_all_n | input | 1 | Global write, active low, writes every lane |
| wr_mask_en_n | input | 1 | Master enable for per-lane writes, active low |
| wr_lane_n | input | LANES | Per-lane write enables, active low |
| snooze | input | 1 | Power-down request, active high, overrides all other inputs |
| out_en_n | input | 1 | Output enable, active low, combinational |
| ilv_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | External word address |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Flow-through read data, zero when not valid |
| dout_vld | output | 1 | Read data valid, stands in for the driven bus |

## Verification
Every edge-decoded result is due in the cycle after the edge that decides it. This covers a new burst address, a beat step or hold, a write, and the switch between read and write cycles. The read data and valid flag for that state settle without a further register. `out_en_n` and `snooze` act on `dout_vld` within the cycle in which they change. The bench therefore changes inputs 2 ns after each rising edge and compares outputs at the falling edge. The reference model then applies that cycle's inputs to its own state, so each comparison sees the state left by the previous edge together with the current asynchronous controls.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_CPU,
    ACC_CTL,
    ACC_CONT
  } acc_e;

  // low address bits for a beat: linear adds the count, interleaved xors it
  function automatic logic [BURST_W-1:0] beat_offset(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] cnt,
    input logic               ilv
  );
    logic [BURST_W-1:0] res;
    if (ilv) res = start ^ cnt;
    else     res = start + cnt;
    return res;
  endfunction

endpackage

// File: rtl/sbsram_wr_decode.sv
module sbsram_wr_decode #(
  parameter int LANES = 2
) (
  input  logic             all_wr_n,
  input  logic             mask_en_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] lane_we,
  output logic             wr_any
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_we
    assign lane_we[g] = !all_wr_n | (!mask_en_n & !lane_n[g]);
  end

  assign wr_any = |lane_we;

endmodule

// File: rtl/sbsram_seq.sv
module sbsram_seq
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snooze,
  input  logic              cpu_stb,
  input  logic              ctl_stb,
  input  logic              prim_en,
  input  logic              sel,
  input  logic              adv,
  input  logic              wr_any,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_en,
  output logic              rd_cycle,
  output logic              active
);

  logic               active_q, active_d;
  logic               rd_q, rd_d;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic               upd;
  acc_e               acc;

  // access classification, strobe priority
  always_comb begin
    if (snooze)                  acc = ACC_NONE;
    else if (cpu_stb && prim_en) acc = ACC_CPU;
    else if (ctl_stb)            acc = ACC_CTL;
    else if (active_q)           acc = ACC_CONT;
    else                         acc = ACC_NONE;
  end

  // next state
  always_comb begin
    active_d = active_q;
    rd_d     = rd_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    wr_en    = 1'b0;
    unique case (acc)
      ACC_CPU: begin
        if (sel) begin
          active_d = 1'b1;
          rd_d     = 1'b1;
          base_d   = addr_in;
          cnt_d    = '0;
        end else begin
          active_d = 1'b0;
        end
      end
      ACC_CTL: begin
        if (sel) begin
          active_d = 1'b1;
          rd_d     = !wr_any;
          base_d   = addr_in;
          cnt_d    = '0;
          wr_en    = wr_any;
        end else begin
          active_d = 1'b0;
        end
      end
      ACC_CONT: begin
        if (adv) cnt_d = cnt_q + 1'b1;
        rd_d  = !wr_any;
        wr_en = wr_any;
      end
      default: ;
    endcase
  end

  assign upd = (acc != ACC_NONE);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b1;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (upd) begin
      active_q <= active_d;
      rd_q     <= rd_d;
      base_q   <= base_d;
      cnt_q    <= cnt_d;
    end
  end

  assign wr_addr  = {base_d[ADDR_W-1:BURST_W], beat_offset(base_d[BURST_W-1:0], cnt_d, ilv)};
  assign cur_addr = {base_q[ADDR_W-1:BURST_W], beat_offset(base_q[BURST_W-1:0], cnt_q, ilv)};
  assign rd_cycle = rd_q;
  assign active   = active_q;

  // R3
  cpu_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && cpu_stb && prim_en && sel)
      |=> (active_q && rd_q && base_q == $past(addr_in) && cnt_q == '0));

  // R6
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && !(cpu_stb && prim_en) && ctl_stb && !sel)
      |=> (!active_q && $stable(base_q)));

  // R7
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && !(cpu_stb && prim_en) && !ctl_stb && active_q && adv)
      |=> (cnt_q == $past(cnt_q) + 2'd1 && $stable(base_q)));

  // R8
  suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && !(cpu_stb && prim_en) && !ctl_stb && active_q && !adv)
      |=> ($stable(cnt_q) && $stable(base_q)));

  // R9
  snooze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |=> ($stable(base_q) && $stable(cnt_q) && $stable(active_q) && $stable(rd_q)));

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && lane_we[g]) mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[rd_addr];
  end

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_n,
  input  logic                    en_hi,
  input  logic                    en_lo_n,
  input  logic                    cpu_ads_n,
  input  logic                    ctl_ads_n,
  input  logic                    burst_adv_n,
  input  logic                    wr_all_n,
  input  logic                    wr_mask_en_n,
  input  logic [LANES-1:0]        wr_lane_n,
  input  logic                    snooze,
  input  logic                    out_en_n,
  input  logic                    ilv_mode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_vld
);

  logic [1:0]              rst_pipe;
  logic                    rst_sync_n;
  logic [LANES-1:0]        lane_we;
  logic                    wr_any;
  logic                    wr_en;
  logic                    rd_cycle;
  logic                    active;
  logic                    sel;
  logic [ADDR_W-1:0]       cur_addr;
  logic [ADDR_W-1:0]       wr_addr;
  logic [LANES*LANE_W-1:0] rdata;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign sel = !en_n & en_hi & !en_lo_n;

  sbsram_wr_decode #(.LANES(LANES)) u_wr_decode (
    .all_wr_n  (wr_all_n),
    .mask_en_n (wr_mask_en_n),
    .lane_n    (wr_lane_n),
    .lane_we   (lane_we),
    .wr_any    (wr_any)
  );

  sbsram_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .snooze   (snooze),
    .cpu_stb  (!cpu_ads_n),
    .ctl_stb  (!ctl_ads_n),
    .prim_en  (!en_n),
    .sel      (sel),
    .adv      (!burst_adv_n),
    .wr_any   (wr_any),
    .ilv      (ilv_mode),
    .addr_in  (addr),
    .cur_addr (cur_addr),
    .wr_addr  (wr_addr),
    .wr_en    (wr_en),
    .rd_cycle (rd_cycle),
    .active   (active)
  );

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .wr_en   (wr_en),
    .lane_we (lane_we),
    .wr_addr (wr_addr),
    .wdata   (din),
    .rd_addr (cur_addr),
    .rdata   (rdata)
  );

  // flow-through output, gated by the asynchronous controls
  assign dout_vld = active & rd_cycle & !out_en_n & !snooze;
  assign dout     = dout_vld ? rdata : '0;

  // R9
  snooze_nowr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    snooze |-> !wr_en);

  // R11
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |=> !dout_vld);

  // R1
  wr_lane_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> (lane_we != '0));

endmodule

// File: tb/sbsram_core_tb.sv
module sbsram_core_tb;

  localparam int AW    = 8;
  localparam int LN    = 2;
  localparam int LW    = 9;
  localparam int WW    = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en_n, en_hi, en_lo_n;
  logic          cpu_ads_n, ctl_ads_n, burst_adv_n;
  logic          wr_all_n, wr_mask_en_n;
  logic [LN-1:0] wr_lane_n;
  logic          snooze, out_en_n, ilv_mode;
  logic [AW-1:0] addr;
  logic [WW-1:0] din;
  logic [WW-1:0] dout;
  logic          dout_vld;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string tag    = "R13";

  logic [WW-1:0] ref_mem   [DEPTH];
  logic [LN-1:0] ref_known [DEPTH];
  logic          m_act, m_rd;
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;

  always #10 clk = ~clk;

  sbsram_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .en_hi(en_hi), .en_lo_n(en_lo_n),
    .cpu_ads_n(cpu_ads_n), .ctl_ads_n(ctl_ads_n), .burst_adv_n(burst_adv_n),
    .wr_all_n(wr_all_n), .wr_mask_en_n(wr_mask_en_n), .wr_lane_n(wr_lane_n),
    .snooze(snooze), .out_en_n(out_en_n), .ilv_mode(ilv_mode),
    .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld)
  );

  // R7: beat address from start and count
  function automatic logic [AW-1:0] m_addr();
    logic [1:0] o;
    o = ilv_mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], o};
  endfunction

  task automatic ref_write(input logic [AW-1:0] a, input logic [LN-1:0] we);
    for (int i = 0; i < LN; i++) begin
      if (we[i]) begin
        ref_mem[a][i*LW +: LW] = din[i*LW +: LW];
        ref_known[a][i] = 1'b1;
      end
    end
  endtask

  // reference for one rising edge, from the current inputs
  task automatic model_edge();
    logic [LN-1:0] we;
    logic          wr, sel;
    for (int i = 0; i < LN; i++) we[i] = !wr_all_n || (!wr_mask_en_n && !wr_lane_n[i]);
    wr  = |we;
    sel = !en_n && en_hi && !en_lo_n;
    if (snooze) return;
    if (!cpu_ads_n && !en_n) begin
      if (sel) begin m_act = 1'b1; m_rd = 1'b1; m_base = addr; m_cnt = 2'd0; end
      else m_act = 1'b0;
    end else if (!ctl_ads_n) begin
      if (sel) begin
        m_act = 1'b1; m_rd = !wr; m_base = addr; m_cnt = 2'd0;
        if (wr) ref_write(addr, we);
      end else m_act = 1'b0;
    end else if (m_act) begin
      if (!burst_adv_n) m_cnt = m_cnt + 2'd1;
      m_rd = !wr;
      if (wr) ref_write(m_addr(), we);
    end
  endtask

  task automatic check_out();
    logic          exp_vld;
    logic [AW-1:0] a;
    exp_vld = m_act && m_rd && !out_en_n && !snooze;
    checks++;
    if (dout_vld !== exp_vld) begin
      fails++;
      $display("FAIL %s: dout_vld=%0b expected %0b at %0t", tag, dout_vld, exp_vld, $time);
    end
    if (exp_vld) begin
      a = m_addr();
      for (int i = 0; i < LN; i++) begin
        if (ref_known[a][i]) begin
          checks++;
          if (dout[i*LW +: LW] !== ref_mem[a][i*LW +: LW]) begin
            fails++;
            $display("FAIL %s: addr %02h lane %0d dout=%03h expected %03h at %0t",
                     tag, a, i, dout[i*LW +: LW], ref_mem[a][i*LW +: LW], $time);
          end
        end
      end
    end else begin
      checks++;
      if (dout !== '0) begin
        fails++;
        $display("FAIL R10: dout=%05h expected 0 while not valid at %0t", dout, $time);
      end
    end
  endtask

  // called at posedge+2 with inputs set; returns at the next posedge+2
  task automatic step();
    @(negedge clk);
    check_out();
    model_edge();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    en_n = 1'b0; en_hi = 1'b1; en_lo_n = 1'b0;
    cpu_ads_n = 1'b1; ctl_ads_n = 1'b1; burst_adv_n = 1'b1;
    wr_all_n = 1'b1; wr_mask_en_n = 1'b1; wr_lane_n = '1;
    snooze = 1'b0; out_en_n = 1'b0;
  endtask

  task automatic rand_inputs();
    logic [31:0] r;
    cpu_ads_n    = ($urandom_range(0, 9) != 0);
    ctl_ads_n    = ($urandom_range(0, 6) != 0);
    burst_adv_n  = ($urandom_range(0, 2) == 0);
    en_n         = ($urandom_range(0, 15) == 0);
    en_hi        = ($urandom_range(0, 15) != 0);
    en_lo_n      = ($urandom_range(0, 15) == 0);
    wr_all_n     = ($urandom_range(0, 3) != 0);
    wr_mask_en_n = ($urandom_range(0, 1) != 0);
    r = $urandom();
    wr_lane_n    = r[LN-1:0];
    snooze       = ($urandom_range(0, 19) == 0);
    out_en_n     = ($urandom_range(0, 7) == 0);
    if ($urandom_range(0, 49) == 0) ilv_mode = ~ilv_mode;
    r = $urandom();
    addr = r[AW-1:0];
    r = $urandom();
    din = r[WW-1:0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R12: watchdog expired, run not complete after %0d cycles (expected fewer)", 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) ref_known[i] = '0;
    m_act = 1'b0; m_rd = 1'b1; m_base = '0; m_cnt = 2'd0;
    idle();
    ilv_mode = 1'b0; addr = '0; din = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R13: nothing valid during and right after reset
    tag = "R13";
    step(); step();
    rst_n = 1'b1;
    repeat (4) step();

    // R5: controller strobe write, then R7 linear advance writes
    tag = "R5";
    ctl_ads_n = 1'b0; addr = 8'h12; wr_all_n = 1'b0; din = 18'h0_1A5; step();
    tag = "R7";
    ctl_ads_n = 1'b1; burst_adv_n = 1'b0;
    for (int i = 1; i < 4; i++) begin din = 18'h1_0300 + 18'(i); step(); end

    // R3: processor strobe ignores write controls, then read burst with wrap
    idle(); tag = "R3";
    cpu_ads_n = 1'b0; addr = 8'h12; wr_all_n = 1'b0; din = 18'h3_FFFF; step();
    idle(); tag = "R7"; burst_adv_n = 1'b0;
    repeat (5) step();
    // R8: wait states repeat the word
    tag = "R8"; burst_adv_n = 1'b1;
    repeat (2) step();
    // R10: output enable high hides data
    tag = "R10"; out_en_n = 1'b1; step(); out_en_n = 1'b0; step();

    // R7: interleaved order from an odd start
    tag = "R7"; ilv_mode = 1'b1;
    cpu_ads_n = 1'b0; addr = 8'h13; step();
    cpu_ads_n = 1'b1; burst_adv_n = 1'b0;
    repeat (5) step();
    ilv_mode = 1'b0;

    // R1: lane-masked writes
    idle(); tag = "R1";
    ctl_ads_n = 1'b0; addr = 8'h10; wr_mask_en_n = 1'b0; wr_lane_n = 2'b10; din = 18'h2_AB55; step();
    idle(); step();
    ctl_ads_n = 1'b0; addr = 8'h11; wr_mask_en_n = 1'b0; wr_lane_n = 2'b01; din = 18'h1_54AA; step();
    idle(); step();

    // R2: write controls not asserted give a read
    tag = "R2";
    ctl_ads_n = 1'b0; addr = 8'h12; wr_mask_en_n = 1'b1; wr_lane_n = 2'b00; din = 18'h0_0000; step();
    idle(); step();
    ctl_ads_n = 1'b0; addr = 8'h13; wr_mask_en_n = 1'b0; wr_lane_n = 2'b11; din = 18'h0_0000; step();
    idle(); step();

    // R4: write follows a processor-started read, R11 output quiet
    tag = "R4";
    cpu_ads_n = 1'b0; addr = 8'h30; wr_all_n = 1'b0; din = 18'h2_2222; step();
    tag = "R11";
    cpu_ads_n = 1'b1; wr_all_n = 1'b0; din = 18'h3_0303; step();
    idle(); tag = "R4"; step(); step();

    // R6: deselect through either strobe
    tag = "R6";
    ctl_ads_n = 1'b0; en_hi = 1'b0; addr = 8'h40; wr_all_n = 1'b0; step();
    idle(); step(); step();
    cpu_ads_n = 1'b0; en_lo_n = 1'b1; addr = 8'h41; step();
    idle(); step(); step();

    // R9: snooze freezes a write burst
    tag = "R9";
    ctl_ads_n = 1'b0; addr = 8'h50; wr_all_n = 1'b0; din = 18'h0_5050; step();
    ctl_ads_n = 1'b1; snooze = 1'b1; burst_adv_n = 1'b0; din = 18'h3_DEAD; step(); step();
    snooze = 1'b0; din = 18'h1_5151; step();
    idle(); cpu_ads_n = 1'b0; addr = 8'h50; step();
    idle(); burst_adv_n = 1'b0; step(); step();
    snooze = 1'b1; step(); snooze = 1'b0; step(); step();

    // R12: random traffic against the reference
    tag = "R12";
    repeat (3000) begin
      rand_inputs();
      step();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule